// File: doc/BRIEF.md
# Translation Cache for Resident Pages

This block keeps a small, fully associative set of recent virtual-to-physical page translations. It sits in front of a page table walker. A lookup that finds its virtual page number answers in the same cycle with the physical address. That address is the cached physical page number with the untouched page offset appended below it. A lookup that misses starts a walk for that page and waits for the answer. If the page table reports the page as resident, the block installs the translation. If it reports the page as absent, the block raises a one-cycle page-fault pulse and installs nothing. Only translations to resident pages are ever held.

Every entry carries a valid flag, a dirty flag and a referenced flag. Any hit marks the entry as referenced. A hit on a store also marks it dirty. When a hit raises either flag above the copy loaded from the page table, the entry becomes out of date with respect to the table. If such an entry is later displaced by an install, its translation and flags go back to the walker on a write-back strobe so the table can be updated. The victim is an invalid entry when one exists. Otherwise it is chosen by a binary-tree pseudo-LRU. A flush input drops every translation at once, for example after the page table base has changed.

The requester holds its request until it sees a hit or a fault. The walker answers a request pulse with a one-cycle done strobe.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no entry is valid, so any lookup misses; the walk request, fault and write-back outputs are low.
- R2: A lookup whose page number matches a valid entry raises the hit output in the same cycle, with physical address = {cached physical page number, page offset of the request}, and starts no walk.
- R3: A lookup that misses while no walk is pending raises the walk request for exactly one cycle, the cycle after the miss, with the missing page number on the walk page output; no further request is issued until the walk completes or is cancelled.
- R4: A done strobe with the present flag set installs the page number, physical page number and the table's dirty and referenced copies; the held request hits in the cycle after the strobe.
- R5: A done strobe with the present flag clear raises the fault output for exactly the cycle after the strobe, installs nothing (a repeated lookup misses again), and produces no write-back.
- R6: Any hit sets the entry's referenced flag, and a hit on a store also sets its dirty flag; both flags are reported in the write-back fields when the entry is evicted.
- R7: The install target is the lowest-numbered invalid entry if any exists; otherwise it is the leaf reached by a pseudo-LRU tree over all entries. Every tree node is steered away from each entry that hits or is installed, and node bit 0 means "left half".
- R8: An install that displaces a valid entry whose dirty or referenced flag was raised by a hit since its install pulses the write-back valid output in the cycle after the done strobe. The pulse carries that entry's page number, physical page number, dirty and referenced flags. Displacing an entry with no such change gives no pulse.
- R9: Flush clears every valid flag at the next edge, suppresses the hit output during its own cycle and cancels a pending walk; a done strobe that arrives after the cancellation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop all translations and cancel a pending walk |
| req_valid_i | input | 1 | Lookup request present |
| req_vaddr_i | input | VA_W | Virtual address to translate |
| req_store_i | input | 1 | Request is a store |
| resp_hit_o | output | 1 | Lookup hit, same cycle |
| resp_paddr_o | output | PPN_W+OFS_W | Physical address for a hit |
| walk_req_o | output | 1 | One-cycle walk request pulse |
| walk_vpn_o | output | VA_W-OFS_W | Page number being walked |
| walk_done_i | input | 1 | Walker answer strobe |
| walk_present_i | input | 1 | Page is resident |
| walk_ppn_i | input | PPN_W | Physical page number from the table |
| walk_dirty_i | input | 1 | Dirty copy held in the table |
| walk_ref_i | input | 1 | Referenced copy held in the table |
| fault_o | output | 1 | One-cycle page-fault pulse |
| wb_valid_o | output | 1 | One-cycle write-back pulse for an evicted entry |
| wb_vpn_o | output | VA_W-OFS_W | Evicted page number |
| wb_ppn_o | output | PPN_W | Evicted physical page number |
| wb_dirty_o | output | 1 | Evicted dirty flag |
| wb_ref_o | output | 1 | Evicted referenced flag |

## Verification
A corrupted tag or valid flag shows at once as a wrong hit or miss on the very next lookup of that page. A corrupted physical page number shows as a wrong address in the same cycle it is read. Flag errors stay hidden until the entry is evicted, so the stimulus fills all entries and then forces evictions whose order and write-back contents expose lost dirty, referenced or out-of-date flags. A wrong replacement tree changes which page number appears on the write-back pulse one cycle after the done strobe. A flush or fault that leaks an install becomes visible as a hit where a miss is due.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_BUSY = 1'b1
  } walk_st_e;

  // True when a hit changes the entry flags away from the table copy.
  function automatic logic hit_raises_flags(input logic dirty_now,
                                            input logic ref_now,
                                            input logic is_store);
    return (is_store & ~dirty_now) | ~ref_now;
  endfunction

endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]          valid_i,
  input  logic [VPN_W-1:0]            tags_i [ENTRIES],
  input  logic [VPN_W-1:0]            vpn_i,
  output logic [ENTRIES-1:0]          hit_vec_o,
  output logic                        hit_any_o,
  output logic [$clog2(ENTRIES)-1:0]  hit_idx_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == vpn_i);
  end

  assign hit_any_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_o[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_repl.sv
`timescale 1ns/1ps
module tlb_repl #(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ENTRIES-1:0]         valid_i,
  input  logic                       touch_a_en_i,
  input  logic [$clog2(ENTRIES)-1:0] touch_a_idx_i,
  input  logic                       touch_b_en_i,
  input  logic [$clog2(ENTRIES)-1:0] touch_b_idx_i,
  output logic [$clog2(ENTRIES)-1:0] victim_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int NODES = ENTRIES - 1;

  logic [NODES-1:0] tree_q;
  logic [NODES-1:0] tree_d;
  logic [IDX_W-1:0] tree_pick;
  logic [IDX_W-1:0] free_pick;
  logic             free_any;

  // Steer every node on the path away from idx (bit 0 = left half).
  function automatic logic [NODES-1:0] tree_touch(input logic [NODES-1:0] t,
                                                  input logic [IDX_W-1:0] idx);
    int node;
    logic b;
    node = 1;
    for (int l = 0; l < IDX_W; l++) begin
      b = idx[IDX_W-1-l];
      t[node-1] = ~b;
      node = 2 * node + (b ? 1 : 0);
    end
    return t;
  endfunction

  function automatic logic [IDX_W-1:0] tree_leaf(input logic [NODES-1:0] t);
    int node;
    logic b;
    logic [IDX_W-1:0] v;
    node = 1;
    v = '0;
    for (int l = 0; l < IDX_W; l++) begin
      b = t[node-1];
      v[IDX_W-1-l] = b;
      node = 2 * node + (b ? 1 : 0);
    end
    return v;
  endfunction

  always_comb begin
    free_any  = 1'b0;
    free_pick = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_any  = 1'b1;
        free_pick = IDX_W'(i);
      end
    end
  end

  assign tree_pick = tree_leaf(tree_q);
  assign victim_o  = free_any ? free_pick : tree_pick;

  always_comb begin
    tree_d = tree_q;
    if (touch_a_en_i) tree_d = tree_touch(tree_d, touch_a_idx_i);
    if (touch_b_en_i) tree_d = tree_touch(tree_d, touch_b_idx_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tree_q <= '0;
    else        tree_q <= tree_d;
  end
endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFS_W   = 12,
  parameter int PPN_W   = 18,
  parameter int ENTRIES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush_i,
  input  logic                    req_valid_i,
  input  logic [VA_W-1:0]         req_vaddr_i,
  input  logic                    req_store_i,
  output logic                    resp_hit_o,
  output logic [PPN_W+OFS_W-1:0]  resp_paddr_o,
  output logic                    walk_req_o,
  output logic [VA_W-OFS_W-1:0]   walk_vpn_o,
  input  logic                    walk_done_i,
  input  logic                    walk_present_i,
  input  logic [PPN_W-1:0]        walk_ppn_i,
  input  logic                    walk_dirty_i,
  input  logic                    walk_ref_i,
  output logic                    fault_o,
  output logic                    wb_valid_o,
  output logic [VA_W-OFS_W-1:0]   wb_vpn_o,
  output logic [PPN_W-1:0]        wb_ppn_o,
  output logic                    wb_dirty_o,
  output logic                    wb_ref_o
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PA_W  = PPN_W + OFS_W;
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [PA_W-1:0] form_paddr(input logic [PPN_W-1:0] ppn,
                                                 input logic [OFS_W-1:0] ofs);
    return {ppn, ofs};
  endfunction

  // Entry storage
  logic [ENTRIES-1:0] ent_valid;
  logic [ENTRIES-1:0] ent_dirty;
  logic [ENTRIES-1:0] ent_ref;
  logic [ENTRIES-1:0] ent_stale;
  logic [VPN_W-1:0]   ent_tag [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];

  logic [VPN_W-1:0]   req_vpn;
  logic [OFS_W-1:0]   req_ofs;
  logic [ENTRIES-1:0] hit_vec;
  logic               match_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim_idx;
  walk_st_e           st_q;

  // Named internal events
  logic lookup_hit;
  logic miss_start;
  logic walk_busy;
  logic walk_accept;
  logic do_install;
  logic do_fault;
  logic evict_news;

  assign req_vpn = req_vaddr_i[VA_W-1:OFS_W];
  assign req_ofs = req_vaddr_i[OFS_W-1:0];

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid_i   (ent_valid),
    .tags_i    (ent_tag),
    .vpn_i     (req_vpn),
    .hit_vec_o (hit_vec),
    .hit_any_o (match_any),
    .hit_idx_o (hit_idx)
  );

  assign walk_busy   = (st_q == WALK_BUSY);
  assign lookup_hit  = req_valid_i && match_any && !flush_i;
  assign miss_start  = req_valid_i && !match_any && !flush_i && !walk_busy;
  assign walk_accept = walk_busy && walk_done_i && !flush_i;
  assign do_install  = walk_accept && walk_present_i;
  assign do_fault    = walk_accept && !walk_present_i;
  assign evict_news  = do_install && ent_valid[victim_idx] && ent_stale[victim_idx];

  tlb_repl #(.ENTRIES(ENTRIES)) u_repl (
    .clk           (clk),
    .rst_n         (rst_n),
    .valid_i       (ent_valid),
    .touch_a_en_i  (lookup_hit),
    .touch_a_idx_i (hit_idx),
    .touch_b_en_i  (do_install),
    .touch_b_idx_i (victim_idx),
    .victim_o      (victim_idx)
  );

  assign resp_hit_o   = lookup_hit;
  assign resp_paddr_o = form_paddr(ent_ppn[hit_idx], req_ofs);

  // Entry update: flush, then install, then hit bookkeeping.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_dirty <= '0;
      ent_ref   <= '0;
      ent_stale <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_tag[i] <= '0;
        ent_ppn[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_i) begin
          ent_valid[i] <= 1'b0;
          ent_stale[i] <= 1'b0;
        end else if (do_install && (victim_idx == IDX_W'(i))) begin
          ent_valid[i] <= 1'b1;
          ent_tag[i]   <= walk_vpn_o;
          ent_ppn[i]   <= walk_ppn_i;
          ent_dirty[i] <= walk_dirty_i;
          ent_ref[i]   <= walk_ref_i;
          ent_stale[i] <= 1'b0;
        end else if (lookup_hit && hit_vec[i]) begin
          ent_dirty[i] <= ent_dirty[i] | req_store_i;
          ent_ref[i]   <= 1'b1;
          ent_stale[i] <= ent_stale[i] |
                          hit_raises_flags(ent_dirty[i], ent_ref[i], req_store_i);
        end
      end
    end
  end

  // Walk sequencing and registered pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= WALK_IDLE;
      walk_req_o <= 1'b0;
      walk_vpn_o <= '0;
      fault_o    <= 1'b0;
      wb_valid_o <= 1'b0;
      wb_vpn_o   <= '0;
      wb_ppn_o   <= '0;
      wb_dirty_o <= 1'b0;
      wb_ref_o   <= 1'b0;
    end else begin
      walk_req_o <= 1'b0;
      fault_o    <= do_fault;
      wb_valid_o <= evict_news;
      if (evict_news) begin
        wb_vpn_o   <= ent_tag[victim_idx];
        wb_ppn_o   <= ent_ppn[victim_idx];
        wb_dirty_o <= ent_dirty[victim_idx];
        wb_ref_o   <= ent_ref[victim_idx];
      end
      case (st_q)
        WALK_IDLE: begin
          if (miss_start) begin
            st_q       <= WALK_BUSY;
            walk_req_o <= 1'b1;
            walk_vpn_o <= req_vpn;
          end
        end
        WALK_BUSY: begin
          if (flush_i || walk_done_i) st_q <= WALK_IDLE;
        end
        default: st_q <= WALK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
`timescale 1ns/1ps
module tlb_xlate_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic               req_valid_i,
  input logic               resp_hit_o,
  input logic               walk_req_o,
  input logic               walk_done_i,
  input logic               walk_present_i,
  input logic               fault_o,
  input logic               wb_valid_o,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               walk_busy
);
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_walk_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_o |=> !walk_req_o);

  p_walk_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_o |-> $past(req_valid_i && !resp_hit_o && !flush_i));

  p_no_rewalk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_busy && $past(walk_busy)) |-> !walk_req_o);

  p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> ($past(walk_done_i && !walk_present_i) && !wb_valid_o));

  p_wb_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> $past(walk_done_i && walk_present_i && !flush_i));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_i) |-> (hit_vec == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flush_i        (flush_i),
  .req_valid_i    (req_valid_i),
  .resp_hit_o     (resp_hit_o),
  .walk_req_o     (walk_req_o),
  .walk_done_i    (walk_done_i),
  .walk_present_i (walk_present_i),
  .fault_o        (fault_o),
  .wb_valid_o     (wb_valid_o),
  .hit_vec        (hit_vec),
  .walk_busy      (walk_busy)
);

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_store_i = 1'b0;
  logic        resp_hit_o;
  logic [29:0] resp_paddr_o;
  logic        walk_req_o;
  logic [19:0] walk_vpn_o;
  logic        walk_done_i = 1'b0;
  logic        walk_present_i = 1'b0;
  logic [17:0] walk_ppn_i = '0;
  logic        walk_dirty_i = 1'b0;
  logic        walk_ref_i = 1'b0;
  logic        fault_o;
  logic        wb_valid_o;
  logic [19:0] wb_vpn_o;
  logic [17:0] wb_ppn_o;
  logic        wb_dirty_o;
  logic        wb_ref_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tlb_xlate u0 (.*);

  // Bench page table: ppn pattern, absent pages end in 8'hEE,
  // referenced copy = vpn bit 1, dirty copy always clear.
  function automatic logic [17:0] pt_ppn(input logic [19:0] v);
    return v[17:0] ^ 18'h2C3A5;
  endfunction

  function automatic logic [45:0] mk(input logic [19:0] v, input logic s, input logic m,
                                     input logic f, input logic w, input logic [19:0] wv,
                                     input logic d, input logic r);
    return {v, s, m, f, w, wv, d, r};
  endfunction

  localparam int NROW = 25;
  localparam logic [45:0] TBL [NROW] = '{
    mk(20'h100, 1, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h101, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h102, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h103, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h104, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h105, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h106, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h107, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h108, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h109, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h10A, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h10B, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h10C, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h10D, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h10E, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h10F, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h200, 0, 1, 0, 1, 20'h100, 1, 1),
    mk(20'h300, 0, 1, 0, 1, 20'h108, 0, 1),
    mk(20'h400, 0, 1, 0, 1, 20'h104, 0, 1),
    mk(20'h10C, 1, 0, 0, 0, 20'h0, 0, 0),
    mk(20'h500, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h5EE, 0, 1, 1, 0, 20'h0, 0, 0),
    mk(20'h5EE, 1, 1, 1, 0, 20'h0, 0, 0),
    mk(20'h600, 0, 1, 0, 0, 20'h0, 0, 0),
    mk(20'h200, 0, 0, 0, 0, 20'h0, 0, 0)
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic run_access(input logic [19:0] vpn, input logic st, input logic [11:0] ofs,
                            input logic exp_miss, input logic exp_fault, input logic exp_wb,
                            input logic [19:0] wvpn, input logic wd, input logic wr);
    req_valid_i = 1'b1;
    req_vaddr_i = {vpn, ofs};
    req_store_i = st;
    #1;
    chk("R2 hit on lookup", 64'(resp_hit_o), 64'(!exp_miss));
    if (!exp_miss) begin
      chk("R2 hit paddr", 64'(resp_paddr_o), 64'({pt_ppn(vpn), ofs}));
      @(negedge clk);
      req_valid_i = 1'b0;
    end else begin
      @(negedge clk);
      chk("R3 walk request", 64'(walk_req_o), 64'd1);
      chk("R3 walk vpn", 64'(walk_vpn_o), 64'(vpn));
      walk_done_i    = 1'b1;
      walk_present_i = (vpn[7:0] != 8'hEE);
      walk_ppn_i     = pt_ppn(vpn);
      walk_dirty_i   = 1'b0;
      walk_ref_i     = vpn[1];
      @(negedge clk);
      walk_done_i = 1'b0;
      chk("R3 walk pulse ended", 64'(walk_req_o), 64'd0);
      chk("R5 fault pulse", 64'(fault_o), 64'(exp_fault));
      chk("R8 write-back pulse", 64'(wb_valid_o), 64'(exp_wb));
      if (exp_wb) begin
        chk("R7 evicted vpn", 64'(wb_vpn_o), 64'(wvpn));
        chk("R8 evicted ppn", 64'(wb_ppn_o), 64'(pt_ppn(wvpn)));
        chk("R6 evicted dirty", 64'(wb_dirty_o), 64'(wd));
        chk("R6 evicted ref", 64'(wb_ref_o), 64'(wr));
      end
      if (exp_fault) begin
        chk("R5 no install", 64'(resp_hit_o), 64'd0);
        req_valid_i = 1'b0;
      end else begin
        chk("R4 hit after install", 64'(resp_hit_o), 64'd1);
        chk("R4 paddr after install", 64'(resp_paddr_o), 64'({pt_ppn(vpn), ofs}));
        @(negedge clk);
        req_valid_i = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset
    req_valid_i = 1'b1;
    req_vaddr_i = 32'h0010_0123;
    #1;
    chk("R1 no hit after reset", 64'(resp_hit_o), 64'd0);
    chk("R1 walk idle", 64'(walk_req_o), 64'd0);
    chk("R1 fault idle", 64'(fault_o), 64'd0);
    chk("R1 write-back idle", 64'(wb_valid_o), 64'd0);
    req_valid_i = 1'b0;
    @(negedge clk);

    // Table walk: fill, evictions in tree order, faults, hits
    for (int i = 0; i < NROW; i++) begin
      logic [45:0] r;
      r = TBL[i];
      run_access(r[45:26], r[25], 12'(i * 53 + 7), r[24], r[23], r[22], r[21:2], r[1], r[0]);
    end

    // R9: flush drops everything; next install finds a free slot (R7), no write-back
    flush_i = 1'b1;
    req_valid_i = 1'b1;
    req_vaddr_i = {20'h200, 12'h044};
    #1;
    chk("R9 hit suppressed during flush", 64'(resp_hit_o), 64'd0);
    @(negedge clk);
    flush_i = 1'b0;
    req_valid_i = 1'b0;
    run_access(20'h200, 1'b0, 12'h044, 1'b1, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0);
    run_access(20'h10C, 1'b0, 12'h0F0, 1'b1, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0);

    // R9: flush cancels a pending walk; the late answer is ignored
    req_valid_i = 1'b1;
    req_vaddr_i = {20'h700, 12'h321};
    req_store_i = 1'b0;
    @(negedge clk);
    chk("R3 walk for cancel case", 64'(walk_req_o), 64'd1);
    flush_i = 1'b1;
    req_valid_i = 1'b0;
    @(negedge clk);
    flush_i = 1'b0;
    walk_done_i = 1'b1;
    walk_present_i = 1'b1;
    walk_ppn_i = pt_ppn(20'h700);
    @(negedge clk);
    walk_done_i = 1'b0;
    chk("R9 late answer no fault", 64'(fault_o), 64'd0);
    chk("R9 late answer no write-back", 64'(wb_valid_o), 64'd0);
    run_access(20'h700, 1'b0, 12'h321, 1'b1, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule